// File: doc/BRIEF.md
# Global History Direction Predictor

This block guesses whether a conditional branch will be taken. It keeps a large table of 2-bit saturating counters. Each counter holds both a direction and a confidence. A counter is chosen by joining a shift register of recent branch outcomes with a few low bits of the fetch address. This makes the predictor two-level: the outcome history picks a counter, and that counter gives the direction.

The lookup side is purely combinational. The fetch address goes in, and the direction, the raw counter value and the current history come out in the same cycle. The update side trains the predictor when a branch resolves. On a clock edge with the update strobe high, it steps the selected counter towards the actual outcome and shifts that outcome into the history. The history changes only at resolution time. Nothing is updated speculatively, and nothing needs recovery.

To keep the storage array shallow, counters are packed several to a row. An update is a read-modify-write of one row, and only one lane of that row changes.

Top module: `gh_dir_predictor`

## Requirements
- R1: After reset every counter holds 1 (weakly not taken) and the history is all zeros. A lookup at any address then returns counter 1, direction 0 and history 0.
- R2: The counter index is {history[HIST_W-1:0], pc[PC_LSB+PC_BITS-1:PC_LSB]}, with history in the upper bits. By default this is {history[9:0], pc[5:2]}, which gives 16384 counters. Address bits outside pc[5:2] have no effect on which counter is chosen.
- R3: The lookup direction is 1 (taken) when the selected counter is 2 or 3, and 0 when it is 0 or 1.
- R4: A valid update whose outcome is taken adds one to the selected counter. A counter already at 3 stays at 3.
- R5: A valid update whose outcome is not taken subtracts one from the selected counter. A counter already at 0 stays at 0.
- R6: Each valid update shifts the history left by one bit and puts the outcome in bit 0 (1 = taken). The oldest bit is dropped, so the last ten outcomes are kept.
- R7: With the update strobe low, no counter and no history bit changes, whatever the update address and outcome inputs carry.
- R8: An update selects its counter with the history as it stands before that update's own shift. A lookup in the same cycle sees the old state, and the new state is visible from the next cycle on.
- R9: An update changes only the selected counter. Counters that differ only in the address bits, including those packed in the same storage row, keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset |
| lk_pc | input | ADDR_W | Fetch address to predict |
| lk_taken | output | 1 | Predicted direction, 1 = taken |
| lk_ctr | output | CTR_W | Selected counter value |
| lk_hist | output | HIST_W | Current outcome history |
| up_valid | input | 1 | Update strobe for a resolved branch |
| up_pc | input | ADDR_W | Address of the resolved branch |
| up_taken | input | 1 | Resolved outcome, 1 = taken |

## Verification
The bench builds the block with its default parameters: a 32-bit address, ten history bits, four address bits starting at bit 2, 2-bit counters and eight counters per storage row. That gives the full 16384-entry table. Long runs of only-taken or only-not-taken updates pin the history at all ones or all zeros, which holds the index still so both saturation limits can be reached. With the history held at zero, changing the address field walks across lanes of one packed row, so training one lane and reading its neighbours tests row isolation. A long random phase, compared every cycle against a model table with default value 1, covers index formation, history shifting and same-cycle lookup against update.

// File: rtl/gh_pkg.sv
package gh_pkg;

  // Named states of a 2-bit counter, kept for readability of parameters
  typedef enum logic [1:0] {
    CTR_STRONG_NT = 2'd0,
    CTR_WEAK_NT   = 2'd1,
    CTR_WEAK_T    = 2'd2,
    CTR_STRONG_T  = 2'd3
  } ctr2_e;

  // Step a w-bit saturating counter towards the outcome
  function automatic logic [7:0] ctr_step(input logic [7:0] cur,
                                          input logic taken,
                                          input int unsigned w);
    logic [7:0] top;
    top = 8'((1 << w) - 1);
    if (taken) return (cur == top) ? cur : cur + 8'd1;
    else       return (cur == 8'd0) ? cur : cur - 8'd1;
  endfunction

  // Upper half of the counter range means taken
  function automatic logic ctr_taken(input logic [7:0] cur,
                                     input int unsigned w);
    return cur >= 8'(1 << (w - 1));
  endfunction

endpackage

// File: rtl/gh_history.sv
module gh_history #(
  parameter int unsigned HIST_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_en,
  input  logic              shift_in,
  output logic [HIST_W-1:0] hist_o
);
  logic [HIST_W-1:0] hist_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        hist_q <= '0;
    else if (shift_en) hist_q <= {hist_q[HIST_W-2:0], shift_in};
  end

  assign hist_o = hist_q;
endmodule

// File: rtl/gh_index.sv
module gh_index #(
  parameter int unsigned HIST_W  = 10,
  parameter int unsigned PC_BITS = 4,
  localparam int unsigned IDX_W  = HIST_W + PC_BITS
) (
  input  logic [HIST_W-1:0]  hist_i,
  input  logic [PC_BITS-1:0] pc_field_i,
  output logic [IDX_W-1:0]   idx_o
);
  assign idx_o = {hist_i, pc_field_i};
endmodule

// File: rtl/gh_counter_table.sv
module gh_counter_table #(
  parameter int unsigned       IDX_W     = 14,
  parameter int unsigned       CTR_W     = 2,
  parameter int unsigned       LANE_LOG2 = 3,
  parameter logic [CTR_W-1:0]  RESET_VAL = CTR_W'(1),
  localparam int unsigned      LANES     = 1 << LANE_LOG2,
  localparam int unsigned      ROW_W     = IDX_W - LANE_LOG2,
  localparam int unsigned      ROWS      = 1 << ROW_W,
  localparam int unsigned      WORD_W    = LANES * CTR_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [CTR_W-1:0] rd_ctr,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_taken,
  output logic [CTR_W-1:0] wr_old,
  output logic [CTR_W-1:0] wr_new
);
  localparam logic [WORD_W-1:0] RST_WORD = {LANES{RESET_VAL}};

  logic [WORD_W-1:0] mem_q [ROWS];

  logic [ROW_W-1:0]     rd_row, wr_row;
  logic [LANE_LOG2-1:0] rd_lane, wr_lane;
  logic [WORD_W-1:0]    rd_word, wr_word_old, wr_word_new;
  logic [7:0]           stepped;

  assign rd_row  = rd_idx[IDX_W-1:LANE_LOG2];
  assign rd_lane = rd_idx[LANE_LOG2-1:0];
  assign wr_row  = wr_idx[IDX_W-1:LANE_LOG2];
  assign wr_lane = wr_idx[LANE_LOG2-1:0];

  assign rd_word     = mem_q[rd_row];
  assign wr_word_old = mem_q[wr_row];

  assign rd_ctr = rd_word[int'(rd_lane)*CTR_W +: CTR_W];
  assign wr_old = wr_word_old[int'(wr_lane)*CTR_W +: CTR_W];

  always_comb begin
    stepped = gh_pkg::ctr_step(8'(wr_old), wr_taken, CTR_W);
    wr_new  = stepped[CTR_W-1:0];
  end

  // One lane takes the stepped value, the rest keep their contents
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign wr_word_new[l*CTR_W +: CTR_W] =
      (wr_lane == LANE_LOG2'(l)) ? wr_new : wr_word_old[l*CTR_W +: CTR_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < ROWS; r++) mem_q[r] <= RST_WORD;
    end else if (wr_en) begin
      mem_q[wr_row] <= wr_word_new;
    end
  end
endmodule

// File: rtl/gh_dir_predictor.sv
module gh_dir_predictor #(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned HIST_W    = 10,
  parameter int unsigned PC_BITS   = 4,
  parameter int unsigned PC_LSB    = 2,
  parameter int unsigned CTR_W     = 2,
  parameter int unsigned LANE_LOG2 = 3,
  parameter int unsigned RESET_CTR = 1,
  localparam int unsigned IDX_W    = HIST_W + PC_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] lk_pc,
  output logic              lk_taken,
  output logic [CTR_W-1:0]  lk_ctr,
  output logic [HIST_W-1:0] lk_hist,
  input  logic              up_valid,
  input  logic [ADDR_W-1:0] up_pc,
  input  logic              up_taken
);
  // Internal events, named for the checker
  logic [HIST_W-1:0] hist_q;
  logic [IDX_W-1:0]  lk_idx, up_idx;
  logic [CTR_W-1:0]  tab_wr_old, tab_wr_new;
  logic              unused_pc_bits;

  assign unused_pc_bits = ^{lk_pc, up_pc};

  gh_history #(.HIST_W(HIST_W)) u_hist (
    .clk(clk), .rst_n(rst_n),
    .shift_en(up_valid), .shift_in(up_taken),
    .hist_o(hist_q)
  );

  gh_index #(.HIST_W(HIST_W), .PC_BITS(PC_BITS)) u_lk_index (
    .hist_i(hist_q), .pc_field_i(lk_pc[PC_LSB +: PC_BITS]), .idx_o(lk_idx)
  );

  gh_index #(.HIST_W(HIST_W), .PC_BITS(PC_BITS)) u_up_index (
    .hist_i(hist_q), .pc_field_i(up_pc[PC_LSB +: PC_BITS]), .idx_o(up_idx)
  );

  gh_counter_table #(
    .IDX_W(IDX_W), .CTR_W(CTR_W), .LANE_LOG2(LANE_LOG2),
    .RESET_VAL(CTR_W'(RESET_CTR))
  ) u_table (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(lk_idx), .rd_ctr(lk_ctr),
    .wr_en(up_valid), .wr_idx(up_idx), .wr_taken(up_taken),
    .wr_old(tab_wr_old), .wr_new(tab_wr_new)
  );

  assign lk_taken = gh_pkg::ctr_taken(8'(lk_ctr), CTR_W);
  assign lk_hist  = hist_q;
endmodule

// File: rtl/gh_dir_predictor_chk.sv
module gh_dir_predictor_chk #(
  parameter int unsigned HIST_W    = 10,
  parameter int unsigned CTR_W     = 2,
  parameter int unsigned IDX_W     = 14,
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned RESET_CTR = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] lk_pc,
  input logic [CTR_W-1:0]  lk_ctr,
  input logic [HIST_W-1:0] lk_hist,
  input logic              up_valid,
  input logic              up_taken,
  input logic [IDX_W-1:0]  lk_idx,
  input logic [IDX_W-1:0]  up_idx,
  input logic [CTR_W-1:0]  wr_old,
  input logic [CTR_W-1:0]  wr_new
);
  localparam logic [CTR_W-1:0] CMAX = '1;

  logic seen_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        seen_q <= 1'b0;
    else if (up_valid) seen_q <= 1'b1;
  end

  p_reset_state_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !seen_q |-> (lk_ctr == CTR_W'(RESET_CTR) && lk_hist == '0));

  p_ports_agree_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (up_valid && lk_idx == up_idx) |-> lk_ctr == wr_old);

  p_up_dir_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (up_valid && up_taken) |-> wr_new >= wr_old);

  p_sat_hi_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (up_valid && up_taken && wr_old == CMAX) |-> wr_new == CMAX);

  p_dn_dir_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (up_valid && !up_taken) |-> wr_new <= wr_old);

  p_sat_lo_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (up_valid && !up_taken && wr_old == '0) |-> wr_new == '0);

  p_hist_shift_r6: assert property (@(posedge clk) disable iff (!rst_n)
    up_valid |=> lk_hist == HIST_W'({$past(lk_hist), $past(up_taken)}));

  p_hist_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !up_valid |=> $stable(lk_hist));

  p_ctr_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !up_valid |=> (!$stable(lk_pc) || $stable(lk_ctr)));
endmodule

bind gh_dir_predictor gh_dir_predictor_chk #(
  .HIST_W(HIST_W), .CTR_W(CTR_W), .IDX_W(IDX_W),
  .ADDR_W(ADDR_W), .RESET_CTR(RESET_CTR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_ctr(lk_ctr),
  .lk_hist(lk_hist), .up_valid(up_valid), .up_taken(up_taken),
  .lk_idx(lk_idx), .up_idx(up_idx),
  .wr_old(tab_wr_old), .wr_new(tab_wr_new)
);

// File: tb/gh_dir_predictor_tb.sv
`timescale 1ns/1ps
module gh_dir_predictor_tb;
  localparam int ADDR_W = 32;
  localparam int HBITS  = 10;
  localparam int FBITS  = 4;
  localparam int FLSB   = 2;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [ADDR_W-1:0] lk_pc = '0;
  logic              lk_taken;
  logic [1:0]        lk_ctr;
  logic [HBITS-1:0]  lk_hist;
  logic              up_valid = 1'b0;
  logic [ADDR_W-1:0] up_pc = '0;
  logic              up_taken = 1'b0;

  always #2.5 clk = ~clk;

  gh_dir_predictor u_dut (
    .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_taken(lk_taken),
    .lk_ctr(lk_ctr), .lk_hist(lk_hist), .up_valid(up_valid),
    .up_pc(up_pc), .up_taken(up_taken)
  );

  // Behavioural model: sparse table, untouched entries read as 1
  int model_tab[int];
  int model_hist = 0;
  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  function automatic int slot(int h, logic [ADDR_W-1:0] pc);
    return (h * (1 << FBITS)) + int'((pc >> FLSB) & ((1 << FBITS) - 1));
  endfunction

  function automatic int peek(int s);
    return model_tab.exists(s) ? model_tab[s] : 1;
  endfunction

  task automatic check(string tag);
    int ec;
    int et;
    ec = peek(slot(model_hist, lk_pc));
    et = (ec >= 2) ? 1 : 0;
    n_cmp++;
    if (int'(lk_ctr) != ec || int'(lk_taken) != et || int'(lk_hist) != model_hist) begin
      n_bad++;
      $display("FAIL %s: taken=%0d ctr=%0d hist=%0h expected taken=%0d ctr=%0d hist=%0h",
               tag, lk_taken, lk_ctr, lk_hist, et, ec, model_hist);
    end
  endtask

  task automatic model_train();
    int s;
    int c;
    if (!up_valid) return;
    s = slot(model_hist, up_pc);
    c = peek(s);
    if (up_taken) c = (c < 3) ? c + 1 : 3;
    else          c = (c > 0) ? c - 1 : 0;
    model_tab[s] = c;
    model_hist = ((model_hist * 2) + int'(up_taken)) % (1 << HBITS);
  endtask

  task automatic step(logic [ADDR_W-1:0] lpc, logic v, logic [ADDR_W-1:0] upc,
                      logic t, string tag);
    @(negedge clk);
    lk_pc = lpc; up_valid = v; up_pc = upc; up_taken = t;
    #1;
    check(tag);
    model_train();
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: run incomplete, actual=hung expected=done");
      finish_run();
    end
  end

  initial begin
    logic [ADDR_W-1:0] pc_a;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state at several addresses
    for (int i = 0; i < 8; i++) step(ADDR_W'($urandom), 1'b0, '0, 1'b0, "R1");

    // R4: only taken, history saturates at all ones, counter at 3
    pc_a = 32'h0000_0014;
    for (int i = 0; i < 16; i++) step(pc_a, 1'b1, pc_a, 1'b1, "R4");
    step(pc_a, 1'b0, '0, 1'b0, "R4 saturated high");

    // R5: only not taken, history goes to zero, counter at 0
    for (int i = 0; i < 16; i++) step(pc_a, 1'b1, pc_a, 1'b0, "R5");
    step(pc_a, 1'b0, '0, 1'b0, "R5 saturated low");

    // R9: history held at zero; train lane 7, read other lanes of the row
    for (int i = 0; i < 4; i++)
      step(32'h0000_0018 + 32'(i % 2) * 4, 1'b1, 32'h0000_001C, 1'b0, "R9");
    for (int f = 0; f < 16; f++) step(32'(f) << FLSB, 1'b0, '0, 1'b0, "R9 neighbour");

    // R2: address bits outside the field do not change the selection
    for (int i = 0; i < 24; i++)
      step((ADDR_W'($urandom) & 32'hFFFF_FFC3) | 32'h0000_001C, 1'b0, '0, 1'b0, "R2");

    // R8: lookup and update of the same counter in one cycle
    for (int i = 0; i < 12; i++) step(32'h0000_0008, 1'b1, 32'h0000_0008, 1'(i % 3 != 0), "R8");

    // R7: strobe low with noisy update inputs
    for (int i = 0; i < 40; i++)
      step(ADDR_W'($urandom), 1'b0, ADDR_W'($urandom), 1'($urandom), "R7");

    // R3 R6: random mix, biased outcomes to reach both halves of the range
    for (int i = 0; i < 6000; i++) begin
      logic [ADDR_W-1:0] p;
      p = ADDR_W'($urandom) & 32'h0000_003C;
      step(($urandom_range(0, 1) == 0) ? p : ADDR_W'($urandom), 1'($urandom_range(0, 3) != 0),
           p, 1'($urandom_range(0, 9) < ((i / 1000) % 2 == 0 ? 8 : 2)), "R3 R6");
    end
    step('0, 1'b0, '0, 1'b0, "R6 final");

    done = 1;
    finish_run();
  end
endmodule